// File: doc/BRIEF.md
# Selectable-Rate Periodic Interrupt Generator

This block turns a fixed 256 Hz timebase into a periodic interrupt at a rate chosen by software. Each base tick arrives as a single-cycle pulse on `baseTick`. A 3-bit rate code in the upper nibble of a byte-wide control register picks the rate. Codes 1 to 4 step down by a factor of four each, from 256 Hz to 4 Hz. Codes 5 and 6 then halve the rate twice, giving 2 Hz and 1 Hz. Codes 0 and 7 stop the source.

When a selected period ends, the block sets a sticky period flag. The interrupt line follows that flag for as long as a nonzero code is loaded. Software acknowledges an event by writing 0 to the flag bit. When the code changes, the internal divider restarts, so the first interval after the change is always a full period.

The block owns only the upper nibble of the control byte (register bits 7:4). Its write and read lanes are therefore four bits wide: lane bit 3 is register bit 7, the period flag, and lane bits 2:0 are register bits 6:4, the rate code. Neighbouring logic owns the lower nibble.

Top module: `periodic_irq_gen`

## Requirements
- R1: While `rstN` is low, the flag and the rate code are 0, `regRdData` reads 0 and `irq` is low.
- R2: A write (`regWrEn` high for one cycle) loads the rate code from `regWrData[2:0]` (register bits 6:4). From the next cycle, `regRdData[2:0]` returns that code.
- R3: With code c loaded and the divider freshly restarted, the flag becomes set one clock after the base tick that completes the period. That tick is the 1st, 4th, 16th, 64th, 128th or 256th tick for c = 1, 2, 3, 4, 5, 6. After one tick fewer, the flag is still clear.
- R4: With code 0 or code 7 loaded, no number of base ticks sets the flag.
- R5: A write with `regWrData[3]` = 0 clears the flag (register bit 7, read at `regRdData[3]`). A write with `regWrData[3]` = 1 leaves the flag unchanged and never sets it.
- R6: If a period completes in the same cycle as a write that clears the flag, the flag ends up set.
- R7: A write whose code differs from the loaded code restarts the divider, so a full period of the new code must pass before the next event. A write of the same code does not disturb the divider.
- R8: `irq` equals the flag whenever the loaded code is nonzero (codes 1 to 7), and is low when the code is 0.
- R9: Once set, the flag stays set through further period events until a clearing write. No count of events is kept, so a single clearing write with no tick in the same cycle leaves the flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baseTick | input | 1 | One-cycle pulse at the 256 Hz base rate |
| regWrEn | input | 1 | Write strobe for the control nibble |
| regWrData | input | 4 | Write lane: bit 3 = flag (write 0 to clear), bits 2:0 = rate code |
| regRdData | output | 4 | Read lane: bit 3 = flag, bits 2:0 = loaded rate code |
| irq | output | 1 | Periodic interrupt request |

## Verification
The hardest situation to reach is the collision between a period completing and a software clear, because both must land on the same clock edge. The stimulus selects code 1, where every base tick completes a period, and drives the tick and the clearing write together on one falling edge. The restart rule is the second hard case: the divider must hold a count well beyond the new code's terminal value when the code changes. To get there, the stimulus runs 200 ticks at code 6, then switches to code 5 and counts ticks up to the first event.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  // Strobes issued by the control side to the datapath each cycle.
  typedef struct packed {
    logic loadCode;    // capture a new rate code
    logic restartDiv;  // zero the tick divider
  } pirqStrobes_t;

  // Log2 of the period in base ticks for a rate code (codes 1..6).
  function automatic int periodShift(input int code);
    if (code <= 4) return 2 * (code - 1);
    return code + 2;
  endfunction

  function automatic bit codeEnabled(input int code);
    return (code >= 1) && (code <= 6);
  endfunction

endpackage

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [CODE_W:0]   regWrData,
  input  logic [CODE_W-1:0] curCode,
  input  logic              periodHit,
  output pirqStrobes_t      strobes,
  output logic [CODE_W-1:0] newCode,
  output logic              flag
);
  localparam int FLAG_POS = CODE_W;

  logic clrFlag;

  always_comb begin
    newCode            = regWrData[CODE_W-1:0];
    strobes.loadCode   = regWrEn;
    strobes.restartDiv = regWrEn && (newCode != curCode);
    clrFlag            = regWrEn && !regWrData[FLAG_POS];
  end

  // A completing period wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flag <= 1'b0;
    else       flag <= (flag && !clrFlag) || periodHit;
  end

endmodule

// File: rtl/pirq_datapath.sv
module pirq_datapath
  import pirq_pkg::*;
#(
  parameter int CODE_W    = 3,
  parameter int MAX_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseTick,
  input  pirqStrobes_t      strobes,
  input  logic [CODE_W-1:0] newCode,
  output logic [CODE_W-1:0] code,
  output logic              periodHit
);
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int DIV_W     = MAX_SHIFT;

  logic [DIV_W-1:0] termTab [NUM_CODES];
  logic             enTab   [NUM_CODES];
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] curTerm;
  logic             curEn;

  // Per-code terminal count and enable, computed from the code value.
  for (genvar g = 0; g < NUM_CODES; g++) begin : gRate
    localparam bit G_EN    = codeEnabled(g);
    localparam int G_SHIFT = G_EN ? periodShift(g) : 0;
    assign enTab[g]   = G_EN;
    assign termTab[g] = G_EN ? DIV_W'((1 << G_SHIFT) - 1) : '0;
  end

  always_comb begin
    curTerm   = termTab[code];
    curEn     = enTab[code];
    periodHit = baseTick && curEn && (divCnt == curTerm) && !strobes.restartDiv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    code <= '0;
    else if (strobes.loadCode)    code <= newCode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               divCnt <= '0;
    else if (strobes.restartDiv || !curEn)   divCnt <= '0;
    else if (baseTick)                       divCnt <= periodHit ? '0 : divCnt + 1'b1;
  end

endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
  import pirq_pkg::*;
#(
  parameter int CODE_W    = 3,
  parameter int MAX_SHIFT = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            baseTick,
  input  logic            regWrEn,
  input  logic [CODE_W:0] regWrData,
  output logic [CODE_W:0] regRdData,
  output logic            irq
);
  pirqStrobes_t      strobes;
  logic [CODE_W-1:0] newCode;
  logic [CODE_W-1:0] code;
  logic              periodHit;
  logic              flag;

  pirq_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .curCode(code), .periodHit(periodHit), .strobes(strobes),
    .newCode(newCode), .flag(flag)
  );

  pirq_datapath #(.CODE_W(CODE_W), .MAX_SHIFT(MAX_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .strobes(strobes),
    .newCode(newCode), .code(code), .periodHit(periodHit)
  );

  assign regRdData = {flag, code};
  assign irq       = flag && (code != '0);

endmodule

// File: rtl/pirq_checker.sv
module pirq_checker #(
  parameter int CODE_W = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            baseTick,
  input logic            regWrEn,
  input logic [CODE_W:0] regWrData,
  input logic [CODE_W:0] regRdData,
  input logic            irq
);
  logic              flagQ;
  logic [CODE_W-1:0] codeQ;
  assign flagQ = regRdData[CODE_W];
  assign codeQ = regRdData[CODE_W-1:0];

  always_ff @(negedge clk) begin
    if (!rstN) begin
      assert_reset_idle_R1: assert (irq == 1'b0 && regRdData == '0);
    end
  end

  assert_code_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> codeQ == $past(regWrData[CODE_W-1:0]));

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!flagQ && (codeQ == '0 || codeQ == '1) && !regWrEn) |=> !flagQ);

  assert_clear_wins_no_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regWrData[CODE_W] && !baseTick) |=> !flagQ);

  assert_irq_follows_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq == (flagQ && codeQ != '0));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !(regWrEn && !regWrData[CODE_W])) |=> flagQ);

endmodule

bind periodic_irq_gen pirq_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .baseTick(baseTick), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
);

// File: tb/test_periodic_irq_gen.sv
module test_periodic_irq_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baseTick = 1'b0;
  logic       regWrEn = 1'b0;
  logic [3:0] regWrData = '0;
  logic [3:0] regRdData;
  logic       irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  periodic_irq_gen i_periodic_irq_gen (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  // Vector table: rate code, ticks applied after a fresh restart, expected flag.
  localparam int NV = 14;
  localparam int V_CODE [NV] = '{1, 1, 2, 2, 3,  3,  4,  4,   5,   5,   6,   6,   0,   7};
  localparam int V_TICK [NV] = '{0, 1, 3, 4, 15, 16, 63, 64, 127, 128, 255, 256, 300, 300};
  localparam int V_FLAG [NV] = '{0, 1, 0, 1, 0,  1,  0,  1,   0,   1,   0,   1,   0,   0};

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) baseTick = 1'b1;
      @(negedge clk) baseTick = 1'b0;
    end
  endtask

  task automatic wrReg(input logic [3:0] d);
    @(negedge clk) begin regWrEn = 1'b1; regWrData = d; end
    @(negedge clk) regWrEn = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", nChecks - nFails + 1, nChecks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd", int'(regRdData), 0);
    check("R1 irq", int'(irq), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      wrReg(4'h0);
      wrReg({1'b0, 3'(V_CODE[v])});
      tickN(V_TICK[v]);
      if (V_CODE[v] == 0 || V_CODE[v] == 7)
        check("R4 disabled flag", int'(regRdData[3]), V_FLAG[v]);
      else
        check("R3 period flag", int'(regRdData[3]), V_FLAG[v]);
    end

    // R2: code readback
    wrReg(4'h3);
    check("R2 code read", int'(regRdData), 3);

    // R5: clear by writing 0, write of 1 does not set
    wrReg(4'h0); wrReg(4'h6);
    tickN(256);
    check("R5 pre flag", int'(regRdData[3]), 1);
    wrReg(4'h6);
    check("R5 clear", int'(regRdData[3]), 0);
    wrReg(4'hE);
    check("R5 one no set", int'(regRdData[3]), 0);

    // R7: same code write keeps divider
    wrReg(4'h0); wrReg(4'h6);
    tickN(100);
    wrReg(4'h6);
    tickN(156);
    check("R7 same code no restart", int'(regRdData[3]), 1);

    // R7: code change restarts divider
    wrReg(4'h0); wrReg(4'h6);
    tickN(200);
    wrReg(4'h5);
    tickN(127);
    check("R7 restart early", int'(regRdData[3]), 0);
    tickN(1);
    check("R7 restart full period", int'(regRdData[3]), 1);

    // R9: sticky, no event count
    wrReg(4'h0); wrReg(4'h1);
    tickN(1);
    tickN(3);
    check("R9 sticky", int'(regRdData[3]), 1);
    wrReg(4'h1);
    check("R9 no backlog", int'(regRdData[3]), 0);

    // R6: tick and clear in the same cycle
    @(negedge clk) begin baseTick = 1'b1; regWrEn = 1'b1; regWrData = 4'h1; end
    @(negedge clk) begin baseTick = 1'b0; regWrEn = 1'b0; end
    check("R6 set wins", int'(regRdData[3]), 1);

    // R8: irq versus code with flag held
    check("R8 irq code1", int'(irq), 1);
    wrReg(4'h8);
    check("R8 rd code0", int'(regRdData), 8);
    check("R8 irq code0", int'(irq), 0);
    wrReg(4'hF);
    check("R8 irq code7", int'(irq), 1);
    wrReg(4'h7);
    check("R8 irq cleared", int'(irq), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule